// File: doc/BRIEF.md
# Serial Flash Command Engine

A register-programmed engine that runs short command frames to serial NOR flash devices. Software fills a 32-bit transmit register, then one write to the command register gives the target bank, the transmit byte count and the receive byte count, and sets a send bit. The engine pulls that bank's chip select low. It clocks the transmit bytes out in SPI mode 0, then clocks in the response bytes. It releases the select and waits out a programmable deselect guard. Last, it sets a sticky transfer-finished flag, and that flag can drive a level interrupt.

Typical uses are an opcode-plus-address frame such as a sector erase, a status poll, or a one-byte opcode followed by a three-byte identification read. A configuration register holds the bank enables, the deselect guard length, the serial clock divider and the software-mode switch that gates the engine.

Top module: `sfc_engine`

## Requirements
- R1: Registers are word-addressed on a 32-bit bus by address bits [4:2] and all reset to zero. The configuration register sits at byte offset 0x0 and holds bank enables in [3:0], guard length D in [7:4], divider P in [15:8] and software mode in bit 28. The command register sits at 0x4 and holds transmit count in [3:0], receive count in [6:4], send in bit 7, interrupt enable in bit 8 and bank in [13:12]. Status is at 0x8 with the finished flag in bit 8. Transmit data is at 0xC and receive data at 0x10. Unlisted bits read 0.
- R2: During a frame, only the selected bank's select is low, for the whole frame. The serial clock idles low and data is stable at each rising edge. Each byte goes out most-significant bit first, and the transmit word goes out from its least-significant byte upward. MOSI is 0 during the receive phase.
- R3: Response bits are sampled on rising serial clock edges. Received bytes fill the receive register from bits [7:0] upward. Bytes not received read 0, because the register is cleared when a frame starts.
- R4: Transmit counts above 4 and receive counts above 4 are treated as 4. When both counts are 0, no select goes low, no clock runs, and the finished flag is set 2 cycles after the command write.
- R5: Each serial clock phase lasts P system cycles, with P=0 treated as 1. After the last byte, the select stays high for D+1 serial clock periods before the flag is set. For T transmit and R receive bytes (T+R>0), the flag is set (16(T+R)+2(D+1))·P+2 cycles after the clock edge that takes the command write.
- R6: The finished flag is sticky. A write to status with bit 8 clear clears it.
- R7: The interrupt output is high exactly while both the finished flag and the interrupt enable are set.
- R8: A send written while a frame or its guard is in progress is dropped. The running frame keeps the bank and counts it started with. The send bit reads 1 from the write until the frame starts, then reads 0.
- R9: A send written while software mode is clear stays pending and starts no frame. Setting software mode later starts it, with R5 timing counted from that configuration write.
- R10: A frame aimed at a bank whose enable bit is clear still runs and sets the flag, but every select stays high.
- R11: No more than one select is low at any time. While idle, the serial clock and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| miso | input | 1 | Serial data from flash |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to flash |
| csN | output | 4 | Active-low bank selects |
| irq | output | 1 | Level interrupt |

## Verification
Every frame's finished flag falls due a fixed number of system cycles after the command write: (16(T+R)+2(D+1))·P+2 cycles, or 2 cycles for an empty frame. The bench counts falling clock edges from that write until the status flag reads set, and compares the count with this closed form. Bits on the serial lines are caught by a bench flash model on serial clock edges, so they are independent of system-clock alignment. The receive register, the send bit and the select history are read or inspected only after the flag is seen, or after a fixed wait when a frame must not start.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;
  localparam int MAX_BYTES = 4;

  localparam logic [2:0] IDX_CFG  = 3'd0;
  localparam logic [2:0] IDX_CMD  = 3'd1;
  localparam logic [2:0] IDX_STAT = 3'd2;
  localparam logic [2:0] IDX_TX   = 3'd3;
  localparam logic [2:0] IDX_RX   = 3'd4;

  typedef struct packed {
    logic start;
    logic sample;
    logic advance;
  } sfcStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GUARD,
    ST_FINISH
  } sfcState_t;
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int DSEL_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrite,
  input  logic [4:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [31:0]          rxData,
  input  logic                 startAck,
  input  logic                 tffSet,
  input  logic                 busy,
  output logic [NUM_BANKS-1:0] bankEn,
  output logic [DSEL_W-1:0]    dselTime,
  output logic [PRESC_W-1:0]   presc,
  output logic                 swMode,
  output logic [31:0]          txWord,
  output logic [2:0]           txLen,
  output logic [2:0]           rxLen,
  output logic [BANK_W-1:0]    bank,
  output logic                 sendPending,
  output logic                 tffFlag,
  output logic                 irq
);
  localparam int DSEL_LSB  = 4;
  localparam int PRESC_LSB = 8;
  localparam int SW_BIT    = 28;
  localparam int RXN_LSB   = 4;
  localparam int SEND_BIT  = 7;
  localparam int IE_BIT    = 8;
  localparam int BANK_LSB  = 12;
  localparam int TFF_BIT   = 8;

  logic [3:0] txField;
  logic [2:0] rxField;
  logic       irqEn;
  logic       wrCfg, wrCmd, wrStat, wrTx;
  logic       unusedAddr;

  assign unusedAddr = ^regAddr[1:0];
  assign wrCfg  = regWrite && (regAddr[4:2] == IDX_CFG);
  assign wrCmd  = regWrite && (regAddr[4:2] == IDX_CMD);
  assign wrStat = regWrite && (regAddr[4:2] == IDX_STAT);
  assign wrTx   = regWrite && (regAddr[4:2] == IDX_TX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankEn      <= '0;
      dselTime    <= '0;
      presc       <= '0;
      swMode      <= 1'b0;
      txField     <= '0;
      rxField     <= '0;
      irqEn       <= 1'b0;
      bank        <= '0;
      txWord      <= '0;
      sendPending <= 1'b0;
      tffFlag     <= 1'b0;
    end else begin
      if (wrCfg) begin
        bankEn   <= regWdata[NUM_BANKS-1:0];
        dselTime <= regWdata[DSEL_LSB +: DSEL_W];
        presc    <= regWdata[PRESC_LSB +: PRESC_W];
        swMode   <= regWdata[SW_BIT];
      end
      if (wrCmd) begin
        txField <= regWdata[3:0];
        rxField <= regWdata[RXN_LSB +: 3];
        irqEn   <= regWdata[IE_BIT];
        bank    <= regWdata[BANK_LSB +: BANK_W];
      end
      if (wrTx) txWord <= regWdata;
      if (startAck) sendPending <= 1'b0;
      else if (wrCmd && regWdata[SEND_BIT] && !busy) sendPending <= 1'b1;
      if (tffSet) tffFlag <= 1'b1;
      else if (wrStat && !regWdata[TFF_BIT]) tffFlag <= 1'b0;
    end
  end

  assign txLen = (txField > 4'd4) ? 3'd4 : txField[2:0];
  assign rxLen = (rxField > 3'd4) ? 3'd4 : rxField;
  assign irq   = tffFlag & irqEn;

  always_comb begin
    regRdata = '0;
    case (regAddr[4:2])
      IDX_CFG: begin
        regRdata[NUM_BANKS-1:0]          = bankEn;
        regRdata[DSEL_LSB +: DSEL_W]     = dselTime;
        regRdata[PRESC_LSB +: PRESC_W]   = presc;
        regRdata[SW_BIT]                 = swMode;
      end
      IDX_CMD: begin
        regRdata[3:0]                    = txField;
        regRdata[RXN_LSB +: 3]           = rxField;
        regRdata[SEND_BIT]               = sendPending;
        regRdata[IE_BIT]                 = irqEn;
        regRdata[BANK_LSB +: BANK_W]     = bank;
      end
      IDX_STAT: regRdata[TFF_BIT] = tffFlag;
      IDX_TX:   regRdata = txWord;
      IDX_RX:   regRdata = rxData;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int DSEL_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sendPending,
  input  logic               swMode,
  input  logic [2:0]         txLen,
  input  logic [2:0]         rxLen,
  input  logic [PRESC_W-1:0] presc,
  input  logic [DSEL_W-1:0]  dselTime,
  output sfcStrobe_t         strobe,
  output logic               tffSet,
  output logic               busy,
  output logic               sclk,
  output logic               frameActive
);
  localparam int BITS_W  = $clog2(2 * MAX_BYTES * 8 + 1);
  localparam int GUARD_W = DSEL_W + 1;

  sfcState_t          state;
  logic [PRESC_W-1:0] divCnt, divLimM1;
  logic [BITS_W-1:0]  bitsLeft;
  logic [GUARD_W-1:0] guardCnt, guardLast;
  logic [3:0]         byteTotal;
  logic               tick, start;

  assign byteTotal = {1'b0, txLen} + {1'b0, rxLen};
  assign divLimM1  = (presc == '0) ? '0 : presc - PRESC_W'(1);
  assign tick      = (divCnt == divLimM1);
  assign guardLast = {dselTime, 1'b1};
  assign start     = (state == ST_IDLE) && sendPending && swMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      sclk     <= 1'b0;
      bitsLeft <= '0;
      guardCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          divCnt <= '0;
          sclk   <= 1'b0;
          if (start) begin
            bitsLeft <= BITS_W'({byteTotal, 3'b000});
            state    <= (byteTotal == 4'd0) ? ST_FINISH : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk     <= 1'b0;
              bitsLeft <= bitsLeft - BITS_W'(1);
              if (bitsLeft == BITS_W'(1)) begin
                state    <= ST_GUARD;
                guardCnt <= '0;
              end
            end
          end else begin
            divCnt <= divCnt + PRESC_W'(1);
          end
        end
        ST_GUARD: begin
          if (tick) begin
            divCnt <= '0;
            if (guardCnt == guardLast) state <= ST_FINISH;
            else guardCnt <= guardCnt + GUARD_W'(1);
          end else begin
            divCnt <= divCnt + PRESC_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.start   = start;
    strobe.sample  = (state == ST_SHIFT) && tick && !sclk;
    strobe.advance = (state == ST_SHIFT) && tick && sclk;
  end

  assign tffSet      = (state == ST_FINISH);
  assign busy        = (state != ST_IDLE);
  assign frameActive = (state == ST_SHIFT);
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  sfcStrobe_t           strobe,
  input  logic                 frameActive,
  input  logic [31:0]          txWord,
  input  logic [2:0]           txLen,
  input  logic [BANK_W-1:0]    bank,
  input  logic [NUM_BANKS-1:0] bankEn,
  input  logic                 miso,
  output logic                 mosi,
  output logic [NUM_BANKS-1:0] csN,
  output logic [31:0]          rxData
);
  logic [31:0]          txQ;
  logic [2:0]           txLenQ;
  logic [BANK_W-1:0]    bankQ;
  logic [NUM_BANKS-1:0] enQ;
  logic [2:0]           byteIdx, bitIdx, rxDiff;
  logic [7:0]           rxShift;
  logic                 rxPhase;
  logic                 unusedRx;

  assign rxPhase  = (byteIdx >= txLenQ);
  assign rxDiff   = byteIdx - txLenQ;
  assign unusedRx = rxDiff[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txQ     <= '0;
      txLenQ  <= '0;
      bankQ   <= '0;
      enQ     <= '0;
      byteIdx <= '0;
      bitIdx  <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else if (strobe.start) begin
      txQ     <= txWord;
      txLenQ  <= txLen;
      bankQ   <= bank;
      enQ     <= bankEn;
      byteIdx <= '0;
      bitIdx  <= '0;
      rxData  <= '0;
    end else begin
      if (strobe.sample) rxShift <= {rxShift[6:0], miso};
      if (strobe.advance) begin
        bitIdx <= bitIdx + 3'd1;
        if (bitIdx == 3'd7) begin
          byteIdx <= byteIdx + 3'd1;
          if (rxPhase) rxData[{rxDiff[1:0], 3'b000} +: 8] <= rxShift;
        end
      end
    end
  end

  assign mosi = (frameActive && !rxPhase) ? txQ[{byteIdx[1:0], ~bitIdx}] : 1'b0;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
    assign csN[g] = ~(frameActive && (bankQ == BANK_W'(g)) && enQ[g]);
  end
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
  import sfc_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int DSEL_W  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrite,
  input  logic [4:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic [3:0]  csN,
  output logic        irq
);
  sfcStrobe_t           strobe;
  logic [NUM_BANKS-1:0] bankEn;
  logic [DSEL_W-1:0]    dselTime;
  logic [PRESC_W-1:0]   presc;
  logic [31:0]          txWord, rxData;
  logic [2:0]           txLen, rxLen;
  logic [BANK_W-1:0]    bank;
  logic                 swMode, sendPending, tffFlag, tffSet, busy, frameActive;

  sfc_regs #(.PRESC_W(PRESC_W), .DSEL_W(DSEL_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxData(rxData),
    .startAck(strobe.start), .tffSet(tffSet), .busy(busy),
    .bankEn(bankEn), .dselTime(dselTime), .presc(presc), .swMode(swMode),
    .txWord(txWord), .txLen(txLen), .rxLen(rxLen), .bank(bank),
    .sendPending(sendPending), .tffFlag(tffFlag), .irq(irq)
  );

  sfc_ctrl #(.PRESC_W(PRESC_W), .DSEL_W(DSEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sendPending(sendPending), .swMode(swMode),
    .txLen(txLen), .rxLen(rxLen), .presc(presc), .dselTime(dselTime),
    .strobe(strobe), .tffSet(tffSet), .busy(busy), .sclk(sclk),
    .frameActive(frameActive)
  );

  sfc_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameActive(frameActive),
    .txWord(txWord), .txLen(txLen), .bank(bank), .bankEn(bankEn),
    .miso(miso), .mosi(mosi), .csN(csN), .rxData(rxData)
  );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker
  import sfc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_BANKS-1:0] csN,
  input logic                 sclk,
  input logic                 mosi,
  input logic                 busy,
  input logic                 sendPending,
  input logic                 tffFlag,
  input logic                 swMode
);
  assert_one_select_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclk && !mosi && (&csN)));

  assert_flag_after_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tffFlag) |-> (&csN));

  assert_pending_consumed_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sendPending) |-> busy);

  assert_swmode_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(swMode));

  assert_clock_in_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> busy);
endmodule

bind sfc_engine sfc_checker u_sfcChecker (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
  .busy(busy), .sendPending(sendPending), .tffFlag(tffFlag), .swMode(swMode)
);

// File: tb/sfc_engine_bench.sv
module sfc_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        miso;
  logic        sclk, mosi, irq;
  logic [3:0]  csN;

  int errors = 0;
  int checks = 0;

  int          bitNo = 0;
  int          slaveTxBits = 0;
  logic [31:0] resp = '0;
  logic [63:0] capVec = '0;
  logic [3:0]  csSeen = '0;
  bit          irqSeen = 0;
  bit          sclkSeen = 0;

  sfc_engine u_sfc_engine (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .miso(miso), .sclk(sclk),
    .mosi(mosi), .csN(csN), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic respBit(int n, int tb, logic [31:0] w);
    int r;
    if (n < tb) return 1'b0;
    r = n - tb;
    if (r >= 32) return 1'b0;
    return w[(r / 8) * 8 + 7 - (r % 8)];
  endfunction

  assign miso = respBit(bitNo, slaveTxBits, resp);

  always @(posedge sclk) begin
    if (bitNo < 64) capVec[bitNo] = mosi;
    bitNo = bitNo + 1;
  end

  always @(negedge clk) begin
    csSeen = csSeen | ~csN;
    if (irq) irqSeen = 1;
    if (sclk) sclkSeen = 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic logic [31:0] cfgWord(logic [3:0] en, logic [3:0] d,
                                          logic [7:0] p, logic sw);
    return {3'b000, sw, 12'h000, p, d, en};
  endfunction

  function automatic int expCycles(int t, int r, int d, int p);
    int pe;
    pe = (p == 0) ? 1 : p;
    if (t + r == 0) return 2;
    return (16 * (t + r) + 2 * (d + 1)) * pe + 2;
  endfunction

  task automatic launch(input logic [3:0] txF, input logic [2:0] rxF,
                        input logic [1:0] bk, input bit ie, input int tBytes);
    bitNo = 0; slaveTxBits = tBytes * 8; capVec = '0;
    csSeen = '0; irqSeen = 0; sclkSeen = 0;
    busWr(5'h04, {18'h0, bk, 3'b000, ie, 1'b1, rxF, txF});
  endtask

  task automatic waitFlag(output int cycles);
    regAddr = 5'h08;
    cycles = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (regRdata[8]) break;
      if (cycles > 5000) break;
    end
  endtask

  task automatic checkStream(input string tag, input logic [31:0] tx,
                             input int t, input int r);
    int bad;
    bad = 0;
    chk(bitNo == (t + r) * 8, {tag, " bit count"}, bitNo, (t + r) * 8);
    for (int k = 0; k < (t + r) * 8 && k < 64; k++) begin
      logic e;
      e = (k < t * 8) ? tx[(k / 8) * 8 + 7 - (k % 8)] : 1'b0;
      if (capVec[k] !== e) bad++;
    end
    chk(bad == 0, {tag, " mosi stream"}, bad, 0);
  endtask

  task automatic clearFlag();
    busWr(5'h08, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(csN == 4'hF && !sclk && !mosi, "R11 idle lines after reset",
        {26'h0, csN, sclk, mosi}, {26'h0, 4'hF, 2'b00});
    chk(!irq, "R7 irq low after reset", irq, 0);
    for (int a = 0; a < 5; a++) begin
      busRd(5'(a * 4), d);
      chk(d == 32'h0, "R1 reset value", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    busWr(5'h00, 32'hFFFF_FFFF);
    busRd(5'h00, d);
    chk(d == 32'h1000_FFFF, "R1 config readback", d, 32'h1000_FFFF);
    busWr(5'h04, 32'hFFFF_FF7F);
    busRd(5'h04, d);
    chk(d == 32'h0000_317F, "R1 command readback", d, 32'h0000_317F);
    busWr(5'h0C, 32'hCAFE_F00D);
    busRd(5'h0C, d);
    chk(d == 32'hCAFE_F00D, "R1 transmit readback", d, 32'hCAFE_F00D);
    busWr(5'h04, 32'h0);
    busWr(5'h00, 32'h0);
  endtask

  task automatic t_erase();
    int c;
    logic [31:0] d;
    busWr(5'h00, cfgWord(4'hF, 4'd1, 8'd2, 1'b1));
    busWr(5'h0C, 32'h5634_12D8);
    launch(4'd4, 3'd0, 2'd2, 1'b1, 4);
    waitFlag(c);
    chk(c == expCycles(4, 0, 1, 2), "R5 erase frame timing", c, expCycles(4, 0, 1, 2));
    chk(csSeen == 4'b0100, "R2 erase select bank 2", csSeen, 4'b0100);
    checkStream("R2 erase", 32'h5634_12D8, 4, 0);
    chk(irq, "R7 irq with enable set", irq, 1);
    clearFlag();
    busRd(5'h08, d);
    chk(d == 32'h0, "R6 flag cleared by write", d, 0);
    chk(!irq, "R7 irq drops with flag", irq, 0);
  endtask

  task automatic t_id();
    int c;
    logic [31:0] d;
    busWr(5'h00, cfgWord(4'hF, 4'd0, 8'd0, 1'b1));
    busWr(5'h0C, 32'h0000_009F);
    resp = 32'hDEC2_2017;
    launch(4'd1, 3'd3, 2'd0, 1'b1, 1);
    waitFlag(c);
    chk(c == expCycles(1, 3, 0, 0), "R5 id read timing, divider 0", c, expCycles(1, 3, 0, 0));
    checkStream("R2 id read", 32'h0000_009F, 1, 3);
    busRd(5'h10, d);
    chk(d == 32'h00C2_2017, "R3 id receive fill", d, 32'h00C2_2017);
    clearFlag();
  endtask

  task automatic t_clamp();
    int c;
    logic [31:0] d;
    busWr(5'h00, cfgWord(4'hF, 4'd0, 8'd1, 1'b1));
    busWr(5'h0C, 32'h8765_4321);
    resp = 32'hA1B2_C3D4;
    launch(4'hF, 3'd7, 2'd3, 1'b1, 4);
    waitFlag(c);
    chk(c == expCycles(4, 4, 0, 1), "R4 clamped counts timing", c, expCycles(4, 4, 0, 1));
    checkStream("R4 clamped", 32'h8765_4321, 4, 4);
    busRd(5'h10, d);
    chk(d == 32'hA1B2_C3D4, "R3 four-byte receive", d, 32'hA1B2_C3D4);
    clearFlag();
  endtask

  task automatic t_zero();
    int c;
    launch(4'd0, 3'd0, 2'd1, 1'b1, 0);
    waitFlag(c);
    chk(c == 2, "R4 empty frame flag delay", c, 2);
    chk(csSeen == 4'b0 && !sclkSeen, "R4 empty frame no select or clock",
        {27'h0, sclkSeen, csSeen}, 0);
    clearFlag();
  endtask

  task automatic t_ieOff();
    int c;
    logic [31:0] d;
    busWr(5'h0C, 32'h0000_0005);
    launch(4'd1, 3'd0, 2'd0, 1'b0, 1);
    waitFlag(c);
    repeat (20) @(negedge clk);
    chk(!irqSeen, "R7 irq stays low with enable clear", irqSeen, 0);
    busRd(5'h08, d);
    chk(d == 32'h0000_0100, "R6 flag sticky", d, 32'h100);
    clearFlag();
  endtask

  task automatic t_busySend();
    int c;
    logic [31:0] d;
    busWr(5'h0C, 32'h1122_3344);
    resp = 32'h0;
    launch(4'd4, 3'd4, 2'd1, 1'b1, 4);
    repeat (20) @(negedge clk);
    busWr(5'h04, {18'h0, 2'd3, 3'b000, 1'b1, 1'b1, 3'd0, 4'd1});
    waitFlag(c);
    chk(csSeen == 4'b0010, "R8 running frame keeps its bank", csSeen, 4'b0010);
    chk(bitNo == 64, "R8 running frame keeps its counts", bitNo, 64);
    busRd(5'h04, d);
    chk(!d[7], "R8 dropped send leaves bit clear", d[7], 0);
    clearFlag();
    csSeen = '0;
    repeat (100) @(negedge clk);
    busRd(5'h08, d);
    chk(d == 32'h0 && csSeen == 4'b0, "R8 no second frame",
        {d[31:4], csSeen}, 0);
  endtask

  task automatic t_swMode();
    int c;
    logic [31:0] d;
    busWr(5'h00, cfgWord(4'hF, 4'd0, 8'd1, 1'b0));
    busWr(5'h0C, 32'h0000_00A5);
    launch(4'd1, 3'd0, 2'd0, 1'b1, 1);
    repeat (40) @(negedge clk);
    chk(csSeen == 4'b0 && !sclkSeen, "R9 no frame while mode clear",
        {27'h0, sclkSeen, csSeen}, 0);
    busRd(5'h04, d);
    chk(d[7], "R9 send stays pending", d[7], 1);
    busRd(5'h08, d);
    chk(d == 32'h0, "R9 no flag while mode clear", d, 0);
    busWr(5'h00, cfgWord(4'hF, 4'd0, 8'd1, 1'b1));
    waitFlag(c);
    chk(c == expCycles(1, 0, 0, 1), "R9 frame starts on mode set", c, expCycles(1, 0, 0, 1));
    checkStream("R9 pending frame", 32'h0000_00A5, 1, 0);
    busRd(5'h04, d);
    chk(!d[7], "R8 send bit self-clears", d[7], 0);
    clearFlag();
  endtask

  task automatic t_bankOff();
    int c;
    busWr(5'h00, cfgWord(4'b1101, 4'd0, 8'd1, 1'b1));
    busWr(5'h0C, 32'h0000_0006);
    launch(4'd1, 3'd0, 2'd1, 1'b1, 1);
    waitFlag(c);
    chk(c == expCycles(1, 0, 0, 1), "R10 disabled bank frame completes", c, expCycles(1, 0, 0, 1));
    chk(csSeen == 4'b0, "R10 disabled bank select stays high", csSeen, 0);
    chk(bitNo == 8, "R10 clock still runs", bitNo, 8);
    clearFlag();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_erase();
    t_id();
    t_clamp();
    t_zero();
    t_ieOff();
    t_busySend();
    t_swMode();
    t_bankOff();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule